// File: doc/BRIEF.md
# Dual-Bus Register Datapath

This block is the register and bus fabric of a small processor. Eight bus registers sit on two shared internal buses, called C and B. Four are general registers R0 to R3, and the other four are the program counter, the memory address register, the memory buffer register and the instruction register. Two ALU holding registers complete the set: Y and Z. Each bus register has four active-low strobes of its own: load from C, drive C, load from B and drive B. A sequencer outside the block drives these strobes cycle by cycle to move words between registers.

The ALU is combinational. Its second operand is always the B bus. One select line chooses between that operand plus one and Y plus that operand. Y loads only from the C bus. Z loads only from the ALU result and drives only the C bus.

Toward memory, the address register drives an address output while its strobe is low. The buffer register exchanges words with an external bidirectional data port. Every register captures on the falling edge of the clock. This leaves the first half of each cycle for the buses and the ALU to settle after the strobes change at the rising edge.

Top module: `dual_bus_datapath`

## Requirements
- R1: A bus register whose C-load strobe is 0 takes the C bus value at the next falling clock edge. A register whose load strobes are all 1 holds its value. Register indices are R0..R3 = 0..3, PC = 4, MAR = 5, MBR = 6, IR = 7.
- R2: A register loads the B bus when its B-load strobe is 0. When both its C-load and B-load strobes are 0, the C bus value is taken.
- R3: Each bus shows the word of the single source whose drive strobe is 0. When no source drives a bus, it reads as all zeros. The source user guarantees at most one driver per bus, and a checker flags any cycle that breaks this.
- R4: Y loads the C bus at a falling edge when its load strobe is 0 and holds otherwise. Y has no path onto either bus.
- R5: Z drives the C bus when its drive strobe is 0 and has no connection to the B bus.
- R6: With the function select at 0, the ALU result is B + 1. With the select at 1, it is Y + B. Both wrap modulo 2^DATA_W. Z captures the result at a falling edge when its load strobe is 0.
- R7: The address output equals MAR while the address strobe is 0, and all zeros otherwise.
- R8: MBR loads the external data port when its external-load strobe is 0. This load takes priority over both bus loads.
- R9: MBR drives the external data port while its external-drive strobe is 0. Otherwise the port is left at high impedance.
- R10: A load at a falling edge is not visible in the half cycle before that edge. A register that loads and drives in the same cycle shows its old value.
- R11: A synchronous active-high reset, sampled at the falling edge, clears all eight bus registers together with Y and Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; registers capture on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| c_in_n | input | NUM_GPR+4 | Per-register load-from-C strobes, active low |
| c_out_n | input | NUM_GPR+4 | Per-register drive-C strobes, active low |
| b_in_n | input | NUM_GPR+4 | Per-register load-from-B strobes, active low |
| b_out_n | input | NUM_GPR+4 | Per-register drive-B strobes, active low |
| y_in_n | input | 1 | Y load-from-C strobe, active low |
| z_in_n | input | 1 | Z load-from-ALU strobe, active low |
| z_out_n | input | 1 | Z drive-C strobe, active low |
| alu_add | input | 1 | ALU select: 0 gives B+1, 1 gives Y+B |
| addr_out_n | input | 1 | MAR to address output strobe, active low |
| mbr_load_ext_n | input | 1 | MBR load-from-port strobe, active low |
| mbr_drive_ext_n | input | 1 | MBR drive-port strobe, active low |
| addr_o | output | DATA_W | External address |
| ext_data | inout | DATA_W | Bidirectional external data port |
| c_bus_o | output | DATA_W | Current C bus word |
| b_bus_o | output | DATA_W | Current B bus word |

## Verification
The bench targets several corner cases, each tied to a specific failure:
- A register with both load strobes low. A design with the wrong load priority would pick up the B word.
- An external load issued together with a C-bus load into MBR. A design with the wrong priority would lose the port word.
- A register that loads while it drives. A design latching on the rising edge would show the new value too early.
- An increment of all ones, which exposes a missing wrap.
- A load from an idle bus, which must clear the register rather than leave stale data.
- Y held across cycles where the C bus is busy, which catches a design that loads Y from the wrong bus.
- A reset in the middle of the run, which catches any register left out of the clear.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

    localparam int SPECIAL_REGS = 4;
    localparam int OFS_PC  = 0;
    localparam int OFS_MAR = 1;
    localparam int OFS_MBR = 2;
    localparam int OFS_IR  = 3;

    typedef enum logic {
        ALU_INC = 1'b0,
        ALU_ADD = 1'b1
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_EXT,
        SRC_CBUS,
        SRC_BBUS
    } load_src_e;

    typedef struct packed {
        logic c_in_n;
        logic b_in_n;
        logic ext_in_n;
    } load_strobe_t;

    // External port first, then C bus, then B bus.
    function automatic load_src_e pick_source(load_strobe_t s);
        if (!s.ext_in_n) return SRC_EXT;
        if (!s.c_in_n)   return SRC_CBUS;
        if (!s.b_in_n)   return SRC_BBUS;
        return SRC_HOLD;
    endfunction

endpackage

// File: rtl/dbd_bus_reg.sv
module dbd_bus_reg
    import dbd_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  load_strobe_t      strobe,
    input  logic [DATA_W-1:0] c_bus,
    input  logic [DATA_W-1:0] b_bus,
    input  logic [DATA_W-1:0] ext_val,
    output logic [DATA_W-1:0] q
);

    load_strobe_t eff;
    load_src_e    src;

    always_comb begin
        eff = strobe;
        if (HAS_EXT == 1'b0) begin
            eff.ext_in_n = 1'b1;
        end
        src = pick_source(eff);
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (src)
                SRC_EXT:  q <= ext_val;
                SRC_CBUS: q <= c_bus;
                SRC_BBUS: q <= b_bus;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/dbd_bus_sel.sv
module dbd_bus_sel #(
    parameter int DATA_W = 16,
    parameter int N_SRC  = 8
) (
    input  logic [N_SRC-1:0]             drv_n,
    input  logic [N_SRC-1:0][DATA_W-1:0] src,
    output logic [DATA_W-1:0]            bus
);

    logic [N_SRC:0][DATA_W-1:0] chain;

    assign chain[0] = '0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_term
        assign chain[i+1] = chain[i] | (src[i] & {DATA_W{~drv_n[i]}});
    end

    assign bus = chain[N_SRC];

endmodule

// File: rtl/dbd_alu.sv
module dbd_alu
    import dbd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] y_op,
    input  logic [DATA_W-1:0] b_op,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] addend;

    assign addend = (fn == ALU_ADD) ? y_op : DATA_W'(1);
    assign result = b_op + addend;

endmodule

// File: rtl/dual_bus_datapath.sv
module dual_bus_datapath
    import dbd_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_GPR = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_GPR+SPECIAL_REGS-1:0]  c_in_n,
    input  logic [NUM_GPR+SPECIAL_REGS-1:0]  c_out_n,
    input  logic [NUM_GPR+SPECIAL_REGS-1:0]  b_in_n,
    input  logic [NUM_GPR+SPECIAL_REGS-1:0]  b_out_n,
    input  logic                             y_in_n,
    input  logic                             z_in_n,
    input  logic                             z_out_n,
    input  logic                             alu_add,
    input  logic                             addr_out_n,
    input  logic                             mbr_load_ext_n,
    input  logic                             mbr_drive_ext_n,
    output logic [DATA_W-1:0]                addr_o,
    inout  wire  [DATA_W-1:0]                ext_data,
    output logic [DATA_W-1:0]                c_bus_o,
    output logic [DATA_W-1:0]                b_bus_o
);

    localparam int NB      = NUM_GPR + SPECIAL_REGS;
    localparam int IDX_MAR = NUM_GPR + OFS_MAR;
    localparam int IDX_MBR = NUM_GPR + OFS_MBR;

    logic [NB-1:0][DATA_W-1:0] reg_q;
    logic [NB:0][DATA_W-1:0]   c_src;
    logic [NB:0]               c_drv_n;
    logic [DATA_W-1:0]         c_bus;
    logic [DATA_W-1:0]         b_bus;
    logic [DATA_W-1:0]         y_q;
    logic [DATA_W-1:0]         z_q;
    logic [DATA_W-1:0]         mbr_q;
    logic [DATA_W-1:0]         alu_res;
    alu_fn_e                   fn;

    for (genvar i = 0; i < NB; i++) begin : g_reg
        load_strobe_t st;
        assign st = '{c_in_n: c_in_n[i], b_in_n: b_in_n[i], ext_in_n: mbr_load_ext_n};
        dbd_bus_reg #(
            .DATA_W  (DATA_W),
            .HAS_EXT (i == IDX_MBR)
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .strobe  (st),
            .c_bus   (c_bus),
            .b_bus   (b_bus),
            .ext_val (ext_data),
            .q       (reg_q[i])
        );
    end

    // Z is the last C-bus source; it never reaches the B bus.
    assign c_src   = {z_q, reg_q};
    assign c_drv_n = {z_out_n, c_out_n};

    dbd_bus_sel #(.DATA_W(DATA_W), .N_SRC(NB + 1)) u_csel (
        .drv_n (c_drv_n),
        .src   (c_src),
        .bus   (c_bus)
    );

    dbd_bus_sel #(.DATA_W(DATA_W), .N_SRC(NB)) u_bsel (
        .drv_n (b_out_n),
        .src   (reg_q),
        .bus   (b_bus)
    );

    assign fn = alu_fn_e'(alu_add);

    dbd_alu #(.DATA_W(DATA_W)) u_alu (
        .fn     (fn),
        .y_op   (y_q),
        .b_op   (b_bus),
        .result (alu_res)
    );

    always_ff @(negedge clk) begin
        if (rst) begin
            y_q <= '0;
            z_q <= '0;
        end else begin
            if (!y_in_n) y_q <= c_bus;
            if (!z_in_n) z_q <= alu_res;
        end
    end

    assign mbr_q    = reg_q[IDX_MBR];
    assign addr_o   = addr_out_n ? '0 : reg_q[IDX_MAR];
    assign ext_data = mbr_drive_ext_n ? {DATA_W{1'bz}} : mbr_q;
    assign c_bus_o  = c_bus;
    assign b_bus_o  = b_bus;

endmodule

// File: rtl/dual_bus_datapath_chk.sv
module dual_bus_datapath_chk #(
    parameter int DATA_W = 16,
    parameter int NBREG  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NBREG-1:0]  c_out_n,
    input logic [NBREG-1:0]  b_out_n,
    input logic              z_out_n,
    input logic              y_in_n,
    input logic              z_in_n,
    input logic              alu_add,
    input logic              addr_out_n,
    input logic              mbr_load_ext_n,
    input logic [DATA_W-1:0] addr_o,
    input logic [DATA_W-1:0] ext_data,
    input logic [DATA_W-1:0] c_bus_o,
    input logic [DATA_W-1:0] b_bus_o,
    input logic [DATA_W-1:0] y_q,
    input logic [DATA_W-1:0] z_q,
    input logic [DATA_W-1:0] mbr_q
);

    assert_single_c_driver_R3: assert property (@(negedge clk) disable iff (rst)
        $countones({~c_out_n, ~z_out_n}) <= 1);

    assert_single_b_driver_R3: assert property (@(negedge clk) disable iff (rst)
        $countones(~b_out_n) <= 1);

    assert_idle_c_zero_R3: assert property (@(negedge clk) disable iff (rst)
        ((&c_out_n) && z_out_n) |-> (c_bus_o == '0));

    assert_addr_idle_R7: assert property (@(negedge clk) disable iff (rst)
        addr_out_n |-> (addr_o == '0));

    assert_y_hold_R4: assert property (@(negedge clk) disable iff (rst)
        y_in_n |=> $stable(y_q));

    assert_y_load_R4: assert property (@(negedge clk) disable iff (rst)
        !y_in_n |=> (y_q == $past(c_bus_o)));

    assert_z_inc_R6: assert property (@(negedge clk) disable iff (rst)
        (!z_in_n && !alu_add) |=> (z_q == DATA_W'($past(b_bus_o) + 1'b1)));

    assert_z_add_R6: assert property (@(negedge clk) disable iff (rst)
        (!z_in_n && alu_add) |=> (z_q == DATA_W'($past(b_bus_o) + $past(y_q))));

    assert_mbr_ext_R8: assert property (@(negedge clk) disable iff (rst)
        !mbr_load_ext_n |=> (mbr_q == $past(ext_data)));

endmodule

bind dual_bus_datapath dual_bus_datapath_chk #(
    .DATA_W (DATA_W),
    .NBREG  (NUM_GPR + 4)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .c_out_n        (c_out_n),
    .b_out_n        (b_out_n),
    .z_out_n        (z_out_n),
    .y_in_n         (y_in_n),
    .z_in_n         (z_in_n),
    .alu_add        (alu_add),
    .addr_out_n     (addr_out_n),
    .mbr_load_ext_n (mbr_load_ext_n),
    .addr_o         (addr_o),
    .ext_data       (ext_data),
    .c_bus_o        (c_bus_o),
    .b_bus_o        (b_bus_o),
    .y_q            (y_q),
    .z_q            (z_q),
    .mbr_q          (mbr_q)
);

// File: tb/dual_bus_datapath_test.sv
module dual_bus_datapath_test;

    localparam int CLK_P = 10;
    localparam int W     = 16;
    localparam int NB    = 8;
    localparam int PC = 4, MAR = 5, MBR = 6, IR = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic [NB-1:0] c_in_n, c_out_n, b_in_n, b_out_n;
    logic          y_in_n, z_in_n, z_out_n, alu_add;
    logic          addr_out_n, mbr_load_ext_n, mbr_drive_ext_n;
    logic [W-1:0]  addr_o, c_bus_o, b_bus_o;
    wire  [W-1:0]  ext_data;
    logic          tb_ext_en;
    logic [W-1:0]  tb_ext_val;

    assign ext_data = tb_ext_en ? tb_ext_val : {W{1'bz}};

    int checks = 0;
    int errors = 0;
    string tag = "R11";

    logic [W-1:0] m_reg [NB];
    logic [W-1:0] m_y, m_z;
    bit m_valid = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_bus_datapath #(.DATA_W(W), .NUM_GPR(4)) uut (
        .clk(clk), .rst(rst),
        .c_in_n(c_in_n), .c_out_n(c_out_n), .b_in_n(b_in_n), .b_out_n(b_out_n),
        .y_in_n(y_in_n), .z_in_n(z_in_n), .z_out_n(z_out_n), .alu_add(alu_add),
        .addr_out_n(addr_out_n), .mbr_load_ext_n(mbr_load_ext_n),
        .mbr_drive_ext_n(mbr_drive_ext_n),
        .addr_o(addr_o), .ext_data(ext_data), .c_bus_o(c_bus_o), .b_bus_o(b_bus_o)
    );

    function automatic logic [NB-1:0] low(int i);
        return ~(NB'(1) << i);
    endfunction

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        rst = 1'b0;
        c_in_n = '1; c_out_n = '1; b_in_n = '1; b_out_n = '1;
        y_in_n = 1'b1; z_in_n = 1'b1; z_out_n = 1'b1; alu_add = 1'b0;
        addr_out_n = 1'b1; mbr_load_ext_n = 1'b1; mbr_drive_ext_n = 1'b1;
        tb_ext_en = 1'b0; tb_ext_val = '0;
    endtask

    // Inputs are set just after a falling edge; compare mid-cycle, then model the next edge.
    task automatic step();
        logic [W-1:0] ec, eb;
        #1;
        ec = '0; eb = '0;
        for (int i = 0; i < NB; i++) begin
            if (!c_out_n[i]) ec = m_reg[i];
            if (!b_out_n[i]) eb = m_reg[i];
        end
        if (!z_out_n) ec = m_z;
        if (m_valid) begin
            check("c bus", c_bus_o, ec);
            check("b bus", b_bus_o, eb);
            check("address", addr_o, addr_out_n ? '0 : m_reg[MAR]);
            if (!mbr_drive_ext_n && !tb_ext_en) check("data port", ext_data, m_reg[MBR]);
        end
        if (rst) begin
            for (int i = 0; i < NB; i++) m_reg[i] = '0;
            m_y = '0; m_z = '0; m_valid = 1;
        end else begin
            if (!z_in_n) m_z = alu_add ? W'(m_y + eb) : W'(eb + 1);
            if (!y_in_n) m_y = ec;
            for (int i = 0; i < NB; i++) begin
                if (i == MBR && !mbr_load_ext_n) m_reg[i] = tb_ext_val;
                else if (!c_in_n[i]) m_reg[i] = ec;
                else if (!b_in_n[i]) m_reg[i] = eb;
            end
        end
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        tag = "R11"; step(); step();
        idle();
        for (int i = 0; i < NB; i++) begin
            c_out_n = low(i); b_out_n = low(i); step();
        end
        idle(); z_out_n = 1'b0; step();

        tag = "R8"; idle(); mbr_load_ext_n = 1'b0; tb_ext_en = 1'b1; tb_ext_val = 16'h1234; step();
        tag = "R9"; idle(); mbr_drive_ext_n = 1'b0; step();
        tag = "R1"; idle(); c_out_n = low(MBR); c_in_n = low(0); step();
        idle(); c_out_n = low(0); step();

        tag = "R2"; idle(); mbr_load_ext_n = 1'b0; tb_ext_en = 1'b1; tb_ext_val = 16'h00FF; step();
        idle(); b_out_n = low(MBR); b_in_n = low(PC); step();
        idle(); c_out_n = low(0); b_out_n = low(PC); c_in_n = low(1); b_in_n = low(1); step();
        idle(); b_out_n = low(1); step();

        tag = "R3"; idle(); b_out_n = low(0); b_in_n = low(3); step();
        idle(); c_in_n = low(3); step();
        idle(); b_out_n = low(3); step();

        tag = "R7"; idle(); c_out_n = low(PC); c_in_n = low(MAR); step();
        idle(); addr_out_n = 1'b0; step();
        idle(); c_out_n = low(MAR); step();

        tag = "R6"; idle(); b_out_n = low(PC); z_in_n = 1'b0; step();
        tag = "R5"; idle(); z_out_n = 1'b0; c_in_n = low(PC); step();
        idle(); b_out_n = low(PC); step();

        tag = "R4"; idle(); c_out_n = low(0); y_in_n = 1'b0; step();
        idle(); b_out_n = low(1); alu_add = 1'b1; z_in_n = 1'b0; step();
        idle(); z_out_n = 1'b0; step();
        idle(); c_out_n = low(PC); step();
        idle(); alu_add = 1'b1; z_in_n = 1'b0; step();
        idle(); z_out_n = 1'b0; step();

        tag = "R6"; idle(); mbr_load_ext_n = 1'b0; tb_ext_en = 1'b1; tb_ext_val = 16'hFFFF; step();
        idle(); b_out_n = low(MBR); z_in_n = 1'b0; step();
        idle(); z_out_n = 1'b0; step();

        tag = "R10"; idle(); c_out_n = low(PC); c_in_n = low(1); b_out_n = low(1); step();
        idle(); b_out_n = low(1); step();

        tag = "R8"; idle(); c_out_n = low(PC); c_in_n = low(MBR);
        mbr_load_ext_n = 1'b0; tb_ext_en = 1'b1; tb_ext_val = 16'hABCD; step();
        idle(); c_out_n = low(MBR); step();

        tag = "R1"; idle(); b_out_n = low(MBR); b_in_n = low(IR); step();
        idle(); c_out_n = low(IR); step();

        tag = "R11"; idle(); rst = 1'b1; step();
        idle(); c_out_n = low(IR); b_out_n = low(PC); step();
        idle(); z_out_n = 1'b0; b_out_n = low(MBR); step();
        idle(); alu_add = 1'b1; z_in_n = 1'b0; step();
        idle(); z_out_n = 1'b0; step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule